// File: doc/BRIEF.md
# Reference Clock Phase Aligner

This block runs on a fast oscillator clock. It produces two timing signals from that clock. The first is a one-cycle enable that marks each rising edge of a divided internal CPU clock. The second is a system clock output, which is a further division of the CPU clock. Both are kept in step with an external reference clock. The reference is asynchronous to the oscillator. It passes through a two-flop synchroniser and a rising-edge detector.

The phase detector compares each detected reference edge with the CPU edge that starts a system clock period. When the two fall in the same oscillator cycle, the CPU divider adds one oscillator cycle to the CPU period that follows. The reference then leads by one oscillator cycle. The internal clock is meant to run slightly fast, so it gains on the reference over time. When the gain reaches one oscillator cycle, the two edges meet again and another stretch follows. No proportional correction is used.

A 3-bit mode input selects the CPU divide ratio. One mode holds the system clock generator in reset so that a tester can synchronise to it. The unused encodings raise an error flag and hold the whole divider in reset. A lock flag reports when the system clock stays within one oscillator cycle of the reference.

Top module: `refclk_phase_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, `cpu_en`, `sysclk_out`, `locked` and `mode_err` are all 0 after that edge.
- R2: Without a stretch, `cpu_en` pulses every D oscillator cycles. D is 1 for modes 3'b101 and 3'b001, 2 for mode 3'b000, 4 for mode 3'b010 and 1 for mode 3'b011.
- R3: The reference path has two synchroniser stages. A rising edge of `ref_in` that is first sampled at clock edge k reaches the phase detector in the cycle after edge k+1, and lasts for one cycle.
- R4: A detected reference edge can fall in the same cycle as a `cpu_en` pulse at which `sysclk_out` rises. In that case the CPU period starting at that pulse lasts D+1 cycles. No other CPU period is lengthened.
- R5: `sysclk_out` divides the CPU clock by SYS_DIV (default 4). It rises together with a `cpu_en` pulse and stays high for SYS_DIV/2 CPU periods, then low for the rest. In a valid, non-holding mode it changes only in cycles where `cpu_en` is high.
- R6: Mode 3'b011 holds `sysclk_out` low and clears the lock, while `cpu_en` keeps pulsing with D=1. After the block leaves a holding mode or reset, the first `cpu_en` pulse raises `sysclk_out`.
- R7: Modes 3'b100, 3'b110 and 3'b111 are invalid. One cycle after one of them is applied, `mode_err` is 1 and `cpu_en` and `sysclk_out` are held at 0. A valid mode clears `mode_err` one cycle later.
- R8: A system clock rising edge counts as aligned when a detected reference edge falls in the same cycle or in the cycle before it. `locked` rises in the cycle after the second consecutive aligned system edge. It falls in the cycle after a system edge that is not aligned, or after a holding or invalid mode is applied.
- R9: Suppose the reference period is one oscillator cycle longer than the nominal system period. The aligner then converges: `locked` becomes 1 and every later system period is stretched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous external reference clock |
| mode | input | 3 | Divide and test mode select |
| cpu_en | output | 1 | One-cycle pulse at each internal CPU clock rising edge |
| sysclk_out | output | 1 | Divided system clock output |
| locked | output | 1 | System clock held within one cycle of the reference |
| mode_err | output | 1 | Invalid mode applied |

## Verification
A change on `mode` shows on `mode_err`, `cpu_en` and the system clock hold one oscillator cycle later. A reference edge reaches the phase detector two cycles after the bench drives it. A stretch shows as the length of the next CPU period. The lock flag updates one cycle after the system edge that decides it. The bench drives inputs and samples outputs at the falling edge. It keeps a short history of its own reference drive and of the sampled outputs, and evaluates each expected value in the sample where that pipeline depth says the result is due. Random modes and reference periods are mixed with directed convergence, hold and invalid-mode phases.

// File: rtl/clkal_pkg.sv
package clkal_pkg;

    localparam int DIV_FULL   = 1;
    localparam int DIV_DOUBLE = 2;
    localparam int DIV_MODULE = 4;
    localparam int MAX_DIV    = DIV_MODULE;
    localparam int DIV_W      = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

    localparam logic [2:0] MODE_DOUBLE = 3'b000;
    localparam logic [2:0] MODE_CHIP   = 3'b001;
    localparam logic [2:0] MODE_MODULE = 3'b010;
    localparam logic [2:0] MODE_SYSRST = 3'b011;
    localparam logic [2:0] MODE_NORMAL = 3'b101;

    typedef struct packed {
        logic             valid;
        logic             sys_hold;
        logic [DIV_W-1:0] last;
    } mode_cfg_t;

    function automatic logic [DIV_W-1:0] ratio_last(input int ratio);
        return DIV_W'(ratio - 1);
    endfunction

    function automatic mode_cfg_t decode_mode(input logic [2:0] m);
        mode_cfg_t c;
        c = '0;
        case (m)
            MODE_NORMAL, MODE_CHIP: begin
                c.valid = 1'b1;
                c.last  = ratio_last(DIV_FULL);
            end
            MODE_DOUBLE: begin
                c.valid = 1'b1;
                c.last  = ratio_last(DIV_DOUBLE);
            end
            MODE_MODULE: begin
                c.valid = 1'b1;
                c.last  = ratio_last(DIV_MODULE);
            end
            MODE_SYSRST: begin
                c.valid    = 1'b1;
                c.sys_hold = 1'b1;
                c.last     = ratio_last(DIV_FULL);
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_async,
    output logic rise,
    output logic rise_d
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            last_q <= 1'b0;
            rise_d <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], ref_async};
            last_q <= chain[STAGES-1];
            rise_d <= rise;
        end
    end

    assign rise = chain[STAGES-1] & ~last_q;

    // edge pulse lasts exactly one cycle
    assert_rise_single_R3: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/cpu_divider.sv
module cpu_divider
    import clkal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] last,
    input  logic             stretch_req,
    output logic             tick,
    output logic             cpu_en
);
    logic [DIV_W-1:0] cdiv;
    logic             pend;
    logic             at_last;
    logic             pend_eff;

    always_comb begin
        at_last  = run && (cdiv >= last);
        pend_eff = pend | stretch_req;
        tick     = at_last && !pend_eff;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cdiv   <= '0;
            pend   <= 1'b0;
            cpu_en <= 1'b0;
        end else begin
            cpu_en <= tick;
            if (at_last) begin
                pend <= 1'b0;
                if (!pend_eff) cdiv <= '0;
            end else begin
                cdiv <= cdiv + 1'b1;
                pend <= pend_eff;
            end
        end
    end

    // a stretch request suppresses the next CPU edge for any ratio
    assert_stretch_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (stretch_req && cpu_en) |=> !cpu_en);

    // divider in reset produces no edges
    assert_stopped_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !run |=> !cpu_en);

endmodule

// File: rtl/sys_clk_gen.sv
module sys_clk_gen #(
    parameter int SYS_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic tick,
    input  logic cpu_en,
    output logic sysclk_out,
    output logic sys_edge
);
    localparam int CNT_W = (SYS_DIV > 2) ? $clog2(SYS_DIV) : 1;
    localparam int LAST  = SYS_DIV - 1;
    localparam int HALF  = SYS_DIV / 2;

    logic [CNT_W-1:0] scnt;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        nxt = (scnt == CNT_W'(LAST)) ? '0 : scnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            scnt       <= CNT_W'(LAST);
            sysclk_out <= 1'b0;
            sys_edge   <= 1'b0;
        end else if (tick) begin
            scnt       <= nxt;
            sysclk_out <= (nxt < CNT_W'(HALF));
            sys_edge   <= (scnt == CNT_W'(LAST));
        end else begin
            sys_edge   <= 1'b0;
        end
    end

    // system clock moves only with a CPU edge unless forced by hold
    assert_moves_on_cpu_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sysclk_out) |-> (cpu_en || $past(hold)));

    assert_edge_is_rise_R5: assert property (@(posedge clk) disable iff (rst)
        sys_edge |-> (sysclk_out && cpu_en));

    assert_hold_low_R6: assert property (@(posedge clk) disable iff (rst)
        hold |=> !sysclk_out);

endmodule

// File: rtl/lock_detect.sv
module lock_detect #(
    parameter int LOCK_EDGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sys_edge,
    input  logic rise,
    input  logic rise_d,
    output logic locked
);
    localparam int CW = $clog2(LOCK_EDGES + 1);

    logic [CW-1:0] good;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            good <= '0;
        end else if (sys_edge) begin
            if (rise || rise_d)
                good <= (good == CW'(LOCK_EDGES)) ? good : good + 1'b1;
            else
                good <= '0;
        end
    end

    assign locked = (good == CW'(LOCK_EDGES));

    assert_lock_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(sys_edge));

    assert_clear_unlocks_R8: assert property (@(posedge clk) disable iff (rst)
        clear |=> !locked);

endmodule

// File: rtl/refclk_phase_aligner.sv
module refclk_phase_aligner
    import clkal_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SYS_DIV     = 4,
    parameter int LOCK_EDGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_in,
    input  logic [2:0] mode,
    output logic       cpu_en,
    output logic       sysclk_out,
    output logic       locked,
    output logic       mode_err
);
    mode_cfg_t cfg;
    logic      hold_sys;
    logic      ref_rise;
    logic      ref_rise_d;
    logic      tick;
    logic      sys_edge;
    logic      stretch_req;

    always_comb begin
        cfg         = decode_mode(mode);
        hold_sys    = !cfg.valid || cfg.sys_hold;
        stretch_req = ref_rise & sys_edge;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_err <= 1'b0;
        else     mode_err <= !cfg.valid;
    end

    ref_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .ref_async (ref_in),
        .rise      (ref_rise),
        .rise_d    (ref_rise_d)
    );

    cpu_divider u_cpu (
        .clk         (clk),
        .rst         (rst),
        .run         (cfg.valid),
        .last        (cfg.last),
        .stretch_req (stretch_req),
        .tick        (tick),
        .cpu_en      (cpu_en)
    );

    sys_clk_gen #(.SYS_DIV(SYS_DIV)) u_sys (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold_sys),
        .tick       (tick),
        .cpu_en     (cpu_en),
        .sysclk_out (sysclk_out),
        .sys_edge   (sys_edge)
    );

    lock_detect #(.LOCK_EDGES(LOCK_EDGES)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .clear    (hold_sys),
        .sys_edge (sys_edge),
        .rise     (ref_rise),
        .rise_d   (ref_rise_d),
        .locked   (locked)
    );

    // an invalid mode never coexists with a CPU edge
    assert_err_blocks_cpu_R7: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> !cpu_en);

endmodule

// File: tb/tb_refclk_phase_aligner.sv
`timescale 1ns/1ps
module tb_refclk_phase_aligner;
    localparam int SYS_DIV = 4;
    localparam int HALF    = SYS_DIV / 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       ref_in;
    logic [2:0] mode;
    logic       cpu_en, sysclk_out, locked, mode_err;

    refclk_phase_aligner dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .mode(mode),
        .cpu_en(cpu_en), .sysclk_out(sysclk_out), .locked(locked), .mode_err(mode_err)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state
    bit h1, h2, h3;
    bit rise_prev, rise_prev2, se_prev, sys_prev_lvl;
    int good_m;
    bit pulse_valid, coin_last;
    int last_pulse, cyc;
    int sys_cnt;
    bit sys_valid, after_hold;
    int refper, refphase;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    function automatic int div_of(input logic [2:0] m);
        case (m)
            3'b101, 3'b001, 3'b011: return 1;
            3'b000: return 2;
            3'b010: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_valid(input logic [2:0] m);
        return div_of(m) != 0;
    endfunction

    function automatic bit is_hold(input logic [2:0] m);
        return !is_valid(m) || m == 3'b011;
    endfunction

    task automatic set_mode(input logic [2:0] m);
        if (m != mode) pulse_valid = 0;
        mode = m;
    endtask

    task automatic step();
        bit rise_now, se_now, nref;
        @(negedge clk);
        cyc++;
        rise_now = h2 & ~h3;            // R3: two sync stages
        se_now   = cpu_en && sysclk_out && !sys_prev_lvl;

        // R8 lock model, decided by the previous sample
        if (is_hold(mode)) good_m = 0;
        else if (se_prev) good_m = (rise_prev || rise_prev2) ? ((good_m < 2) ? good_m + 1 : 2) : 0;
        chk("R8 lock (ref latency R3)", locked, good_m >= 2);

        chk("R7 mode_err", mode_err, !is_valid(mode));
        if (!is_valid(mode)) begin
            chk("R7 cpu_en held", cpu_en, 0);
            chk("R7 sysclk held", sysclk_out, 0);
        end
        if (mode == 3'b011) chk("R6 sysclk held low", sysclk_out, 0);

        // R2 / R4 CPU period
        if (cpu_en) begin
            if (pulse_valid) begin
                if (coin_last) chk("R4 stretched period", cyc - last_pulse, div_of(mode) + 1);
                else           chk("R2 period", cyc - last_pulse, div_of(mode));
            end
            pulse_valid = 1;
            last_pulse  = cyc;
            coin_last   = se_now && rise_now;
        end

        // R5 / R6 system clock
        if (is_hold(mode)) begin
            sys_valid  = 0;
            after_hold = 1;
        end else begin
            if (after_hold && cpu_en) begin
                chk("R6 first edge raises sysclk", sysclk_out && !sys_prev_lvl, 1);
                after_hold = 0;
            end
            if (sysclk_out != sys_prev_lvl) begin
                chk("R5 change with cpu_en", cpu_en, 1);
                if (sys_valid)
                    chk("R5 phase length", sys_cnt, sysclk_out ? SYS_DIV - HALF : HALF);
                sys_cnt = 1;
                if (sysclk_out) sys_valid = 1;
            end else if (cpu_en) begin
                sys_cnt++;
            end
        end

        se_prev      = se_now;
        rise_prev2   = rise_prev;
        rise_prev    = rise_now;
        sys_prev_lvl = sysclk_out;

        refphase = (refphase + 1) % refper;
        nref     = (refphase < refper / 2);
        h3 = h2; h2 = h1; h1 = nref;
        ref_in = nref;
    endtask

    task automatic run_phase(input logic [2:0] m, input int per, input int n);
        set_mode(m);
        refper   = per;
        refphase = refphase % refper;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst = 1; mode = 3'b101; ref_in = 0;
        h1 = 0; h2 = 0; h3 = 0;
        rise_prev = 0; rise_prev2 = 0; se_prev = 0; sys_prev_lvl = 0;
        good_m = 0; pulse_valid = 0; coin_last = 0; last_pulse = 0; cyc = 0;
        sys_cnt = 0; sys_valid = 0; after_hold = 1;
        refper = 5; refphase = 3;
        repeat (3) @(negedge clk);
        chk("R1 cpu_en", cpu_en, 0);
        chk("R1 sysclk_out", sysclk_out, 0);
        chk("R1 locked", locked, 0);
        chk("R1 mode_err", mode_err, 0);
        rst = 0;

        run_phase(3'b101, 5, 80);
        chk("R9 locked ratio 1", locked, 1);
        run_phase(3'b000, 9, 200);
        chk("R9 locked ratio 2", locked, 1);
        run_phase(3'b010, 17, 500);
        chk("R9 locked ratio 4", locked, 1);
        run_phase(3'b011, 5, 30);
        chk("R6 lock cleared", locked, 0);
        refphase = $urandom_range(0, 15);
        run_phase(3'b010, 16 + $urandom_range(0, 1), 400);
        run_phase(3'b100, 7, 20);
        run_phase(3'b110, 7, 20);
        run_phase(3'b111, 7, 20);
        run_phase(3'b001, 5, 200);
        chk("R9 locked after invalid", locked, 1);

        for (int it = 0; it < 10; it++) begin
            logic [2:0] m;
            int per;
            m   = 3'($urandom_range(0, 7));
            per = is_valid(m) ? div_of(m) * SYS_DIV + $urandom_range(0, 2) : 7;
            refphase = $urandom_range(0, per - 1);
            run_phase(m, per, $urandom_range(50, 250));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule